// File: doc/BRIEF.md
# Hibernation Power Sequencer

This block lives in an always-on supply domain and drives an active-high regulator enable. Software parks the system by issuing a self-clearing power-cut command through a small register interface. The enable then drops and main power goes away. Power returns when an enabled wake source fires. One wake source is a level on an external wake pin. The other is a seconds counter that equals one of two programmed compare values.

A low-battery comparator output is sampled as a plain input. When low-battery monitoring is enabled it raises an interrupt source. A separate abort bit makes the block refuse a power-cut command while the battery is low. The seconds counter is driven in one of two ways. It can take slow-clock pulses directly, or fast-oscillator pulses divided by 2^DIV_W. In both cases a 2^PRESC_W prescaler follows. The counter can be loaded by software. Four interrupt sources have sticky raw bits, a mask, a masked view and a write-one-to-clear action.

Top module: `hib_power_seq`

## Requirements
- R1: After reset, pwr_en_o is 1 and irq_o is 0. Control, count, mask and raw status read 0, and both compare registers read all ones.
- R2: A write to address 0 with wdata bit 0 set while pwr_en_o is 1 is an accepted power-cut command unless R3 applies. It drives pwr_en_o to 0 at the same clock edge that performs the write. Bit 0 always reads back as 0.
- R3: If the power-cut write also has bit 6 (abort-on-low-battery) set and lowbat_i is 1, the command is refused and pwr_en_o stays 1.
- R4: While pwr_en_o is 0, wake_pin_i high with control bit 3 set raises pwr_en_o at the next edge. With bit 3 clear the pin has no effect, and without a wake event pwr_en_o stays 0.
- R5: While pwr_en_o is 0 with control bit 4 set, the count equalling compare 0 (address 2) or compare 1 (address 3) raises pwr_en_o at the next edge.
- R6: Control bit 1 enables counting. With bit 2 clear, the count advances once per 2^PRESC_W slow_tick_i pulses. With bit 2 set, it advances once per 2^(PRESC_W+DIV_W) fast_tick_i pulses. With bit 1 clear the count does not change.
- R7: A write to address 1 sets the count (read back at address 1) and clears the prescaler and divider. It takes priority over a tick in the same cycle.
- R8: Raw status (address 5 read) is sticky. Bit 0 is set on count equal to compare 0, bit 1 on count equal to compare 1, bit 2 on lowbat_i with control bit 5, and bit 3 on wake_pin_i with control bit 3.
- R9: Writing address 5 clears the raw bits whose wdata bits are 1. A set event in the same cycle wins over the clear.
- R10: Address 4 holds the 4-bit mask. Address 6 reads raw AND mask, and irq_o is the OR of those masked bits. Address 7 reads pwr_en_o in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rd_data | output | CNT_W | Read data for addr (combinational) |
| slow_tick_i | input | 1 | Slow-clock pulse, one per slow period |
| fast_tick_i | input | 1 | Fast-oscillator pulse |
| wake_pin_i | input | 1 | External wake level |
| lowbat_i | input | 1 | Low-battery comparator output |
| pwr_en_o | output | 1 | Regulator enable, 1 = main power on |
| irq_o | output | 1 | Interrupt request |

## Verification
A software clear of raw status and a fresh status event can land on the same clock edge. The bench provokes this by holding lowbat_i high with monitoring on while writing a clear of bit 2. It also writes a clear while the count still equals compare 1. The reference model expects the bit to survive, and irq_o is compared every cycle. A load write made on the same edge as a slow tick is also judged: the loaded value must stand and the prescaler must restart from zero.

// File: rtl/hib_power_seq.sv
module hib_power_seq #(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 15,
  parameter int DIV_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rd_data,
  input  logic             slow_tick_i,
  input  logic             fast_tick_i,
  input  logic             wake_pin_i,
  input  logic             lowbat_i,
  output logic             pwr_en_o,
  output logic             irq_o
);
  localparam int NSRC = 4;

  logic [6:1]         ctrl_q;
  logic [CNT_W-1:0]   count_q, match0_q, match1_q;
  logic [PRESC_W-1:0] presc_q;
  logic [DIV_W-1:0]   div_q;
  logic [NSRC-1:0]    mask_q, raw_q, events, clr;
  logic [7:0]         wsel;
  logic               pwr_q, hit0, hit1, src_tick, sec_tick, hib_req, wake;

  assign wsel     = wr_en ? (8'b1 << addr) : 8'b0;
  assign hit0     = (count_q == match0_q);
  assign hit1     = (count_q == match1_q);
  assign hib_req  = wsel[0] && wdata[0] && pwr_q && !(wdata[6] && lowbat_i);
  assign wake     = !pwr_q && ((ctrl_q[3] && wake_pin_i) || (ctrl_q[4] && (hit0 || hit1)));
  assign src_tick = ctrl_q[1] && (ctrl_q[2] ? (fast_tick_i && (&div_q)) : slow_tick_i);
  assign sec_tick = src_tick && (&presc_q);
  assign events   = {ctrl_q[3] && wake_pin_i, ctrl_q[5] && lowbat_i, hit1, hit0};
  assign clr      = wsel[5] ? wdata[NSRC-1:0] : '0;
  assign pwr_en_o = pwr_q;
  assign irq_o    = |(raw_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q    <= 1'b1;
      ctrl_q   <= '0;
      count_q  <= '0;
      match0_q <= '1;
      match1_q <= '1;
      presc_q  <= '0;
      div_q    <= '0;
      mask_q   <= '0;
      raw_q    <= '0;
    end else begin
      if (hib_req)   pwr_q <= 1'b0;
      else if (wake) pwr_q <= 1'b1;
      if (wsel[0]) ctrl_q   <= wdata[6:1];
      if (wsel[2]) match0_q <= wdata;
      if (wsel[3]) match1_q <= wdata;
      if (wsel[4]) mask_q   <= wdata[NSRC-1:0];
      raw_q <= (raw_q & ~clr) | events;
      if (wsel[1]) begin
        count_q <= wdata;
        presc_q <= '0;
        div_q   <= '0;
      end else begin
        if (ctrl_q[1] && ctrl_q[2] && fast_tick_i) div_q <= div_q + 1'b1;
        if (src_tick) presc_q <= presc_q + 1'b1;
        if (sec_tick) count_q <= count_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = CNT_W'({ctrl_q, 1'b0});
      3'd1:    rd_data = count_q;
      3'd2:    rd_data = match0_q;
      3'd3:    rd_data = match1_q;
      3'd4:    rd_data = CNT_W'(mask_q);
      3'd5:    rd_data = CNT_W'(raw_q);
      3'd6:    rd_data = CNT_W'(raw_q & mask_q);
      default: rd_data = CNT_W'(pwr_q);
    endcase
  end
endmodule

module hib_power_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [6:0] wdata_lo,
  input logic       lowbat_i,
  input logic       wake_pin_i,
  input logic       pwr_en_o,
  input logic [6:1] ctrl_q,
  input logic       hit0,
  input logic       hit1,
  input logic [3:0] raw_q
);
  // R2
  hib_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wdata_lo[0] && pwr_en_o && !(wdata_lo[6] && lowbat_i)) |=> !pwr_en_o);
  // R3
  lowbat_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wdata_lo[0] && wdata_lo[6] && lowbat_i && pwr_en_o) |=> pwr_en_o);
  // R4
  pin_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en_o && ctrl_q[3] && wake_pin_i) |=> pwr_en_o);
  // R5
  match_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en_o && ctrl_q[4] && (hit0 || hit1)) |=> pwr_en_o);
  // R4
  stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en_o && !(ctrl_q[3] && wake_pin_i) && !(ctrl_q[4] && (hit0 || hit1))) |=> !pwr_en_o);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[5] && lowbat_i) |=> raw_q[2]);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q[0] && !(wr_en && addr == 3'd5 && wdata_lo[0])) |=> raw_q[0]);
endmodule

bind hib_power_seq hib_power_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata_lo(wdata[6:0]),
  .lowbat_i(lowbat_i), .wake_pin_i(wake_pin_i), .pwr_en_o(pwr_en_o),
  .ctrl_q(ctrl_q), .hit0(hit0), .hit1(hit1), .raw_q(raw_q)
);

// File: tb/hib_power_seq_test.sv
module hib_power_seq_test;
  localparam int PW = 3;
  localparam int DW = 7;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rd_data;
  logic slow = 1'b0, fast = 1'b0, pin = 1'b0, lowbat = 1'b0;
  logic pwr_en, irq;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hib_power_seq #(.CNT_W(32), .PRESC_W(PW), .DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .slow_tick_i(slow), .fast_tick_i(fast),
    .wake_pin_i(pin), .lowbat_i(lowbat), .pwr_en_o(pwr_en), .irq_o(irq));

  // reference model
  bit m_pwr;
  logic [6:0] m_ctrl;
  logic [31:0] m_cnt, m_m0, m_m1;
  logic [3:0] m_mask, m_raw;
  int m_presc, m_div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 1; m_ctrl = 0; m_cnt = 0; m_m0 = '1; m_m1 = '1;
      m_mask = 0; m_raw = 0; m_presc = 0; m_div = 0;
    end else begin : step
      bit h0, h1, src, wk, rq;
      logic [3:0] ev, cl;
      h0 = (m_cnt == m_m0);
      h1 = (m_cnt == m_m1);
      ev = {m_ctrl[3] && pin, m_ctrl[5] && lowbat, h1, h0};
      wk = !m_pwr && ((m_ctrl[3] && pin) || (m_ctrl[4] && (h0 || h1)));
      rq = wr_en && addr == 0 && wdata[0] && m_pwr && !(wdata[6] && lowbat);
      cl = (wr_en && addr == 5) ? wdata[3:0] : 4'h0;
      src = 0;
      if (m_ctrl[1]) begin
        if (m_ctrl[2]) begin
          if (fast) begin
            if (m_div == (1 << DW) - 1) src = 1;
            m_div = (m_div + 1) % (1 << DW);
          end
        end else if (slow) src = 1;
      end
      if (src) begin
        m_presc = (m_presc + 1) % (1 << PW);
        if (m_presc == 0) m_cnt = m_cnt + 1;
      end
      if (wr_en && addr == 1) begin m_cnt = wdata; m_presc = 0; m_div = 0; end
      if (rq) m_pwr = 0; else if (wk) m_pwr = 1;
      if (wr_en && addr == 0) m_ctrl = {wdata[6:1], 1'b0};
      if (wr_en && addr == 2) m_m0 = wdata;
      if (wr_en && addr == 3) m_m1 = wdata;
      if (wr_en && addr == 4) m_mask = wdata[3:0];
      m_raw = (m_raw & ~cl) | ev;
    end
  end

  // R4 R5 R2 R10: outputs compared on every clock
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (pwr_en !== m_pwr) begin
      fails++; $display("FAIL R2/R4/R5 pwr_en_o cycle %0d: got %0b exp %0b", cyc, pwr_en, m_pwr);
    end
    checks++;
    if (irq !== |(m_raw & m_mask)) begin
      fails++; $display("FAIL R10 irq_o cycle %0d: got %0b exp %0b", cyc, irq, |(m_raw & m_mask));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      fails++; $display("FAIL %s addr %0d: got %h exp %h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++; $display("FAIL %s: got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic slow_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow = 1;
      @(negedge clk); slow = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(pwr_en, 1'b1, "R1 pwr_en");
    chk(irq, 1'b0, "R1 irq");
    rd(0, 0, "R1 ctrl"); rd(1, 0, "R1 count"); rd(2, 32'hFFFF_FFFF, "R1 match0");
    rd(3, 32'hFFFF_FFFF, "R1 match1"); rd(4, 0, "R1 mask"); rd(5, 0, "R1 raw");

    // R6 counting from slow pulses, frozen, then fast divided path
    wr(0, 32'h2);
    slow_pulses(8);
    rd(1, 1, "R6 slow count");
    wr(0, 32'h0);
    slow_pulses(8);
    rd(1, 1, "R6 frozen count");
    wr(0, 32'h6);
    @(negedge clk); fast = 1;
    repeat (1 << (PW + DW)) @(negedge clk);
    fast = 0;
    rd(1, 2, "R6 fast count");

    // R7 load, load colliding with a tick
    wr(0, 32'h2);
    wr(1, 100);
    rd(1, 100, "R7 load");
    @(negedge clk); wr_en = 1; addr = 1; wdata = 200; slow = 1;
    @(negedge clk); wr_en = 0; slow = 0;
    slow_pulses(7);
    rd(1, 200, "R7 load wins over tick");
    slow_pulses(1);
    rd(1, 201, "R7 prescaler cleared");

    // R2 hibernate entry
    wr(0, 32'h3);
    chk(pwr_en, 1'b0, "R2 power cut");
    rd(0, 32'h2, "R2 command self-clears");
    rd(7, 0, "R10 power status");

    // R4 pin ignored with enable clear, then wake
    pin = 1;
    repeat (3) @(negedge clk);
    chk(pwr_en, 1'b0, "R4 pin ignored");
    wr(0, 32'hA);
    @(negedge clk);
    chk(pwr_en, 1'b1, "R4 pin wake");
    pin = 0;

    // R3 low-battery abort
    lowbat = 1;
    wr(0, 32'h43);
    chk(pwr_en, 1'b1, "R3 abort");
    lowbat = 0;

    // R5 wake by compare 0
    wr(2, 502); wr(1, 500); wr(0, 32'h13);
    chk(pwr_en, 1'b0, "R5 off before match0");
    slow_pulses(16);
    @(negedge clk);
    chk(pwr_en, 1'b1, "R5 wake by match0");
    rd(1, 502, "R5 count at match0");

    // R5 wake by compare 1
    wr(2, 32'hFFFF_FFFF); wr(3, 504); wr(0, 32'h13);
    chk(pwr_en, 1'b0, "R5 off before match1");
    slow_pulses(16);
    @(negedge clk);
    chk(pwr_en, 1'b1, "R5 wake by match1");

    // R8 raw status, R9 clear, R10 masking
    rd(5, 32'hB, "R8 raw sticky");
    wr(4, 32'hF);
    wr(5, 32'hF);
    rd(5, 32'h2, "R9 clear with match1 still equal");
    wr(0, 32'h22); lowbat = 1;
    @(negedge clk);
    rd(5, 32'h6, "R8 lowbat raw");
    wr(5, 32'h4);
    rd(5, 32'h6, "R9 set wins over clear");
    lowbat = 0;
    wr(5, 32'h4);
    rd(5, 32'h2, "R9 clear");
    wr(3, 32'hFFFF_FFFF);
    wr(5, 32'h2);
    wr(4, 32'h1);
    rd(6, 0, "R10 masked zero");
    chk(irq, 1'b0, "R10 irq off");
    lowbat = 1;
    @(negedge clk);
    wr(4, 32'h4);
    rd(6, 32'h4, "R10 masked lowbat");
    chk(irq, 1'b1, "R10 irq on");
    lowbat = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule